// File: doc/BRIEF.md
# Single-Wire Gauge Bus Host over UART Characters

This block is the host side of a single-wire, open-drain bus of the kind used to talk to battery fuel gauges. It uses a full UART character to carry each bus bit. A character's data pattern sets how long the line stays low, and the bus target reads that low time as a 1 or a 0. When the target answers, the block receives one UART character for each returned bit. It turns each character into a logic level by comparing it with a fixed threshold, so a slow rising edge on a loaded wire does not cause a wrong bit.

A transaction begins with a pulse on `start`. The block then sends a command byte, which holds a 7-bit register address and a read flag. A write follows the command with a data byte from the host. A read follows it by releasing the wire and collecting eight answer characters, which become the read byte. The block drives the wire only through a pull-low enable and never drives it high. It senses the wire on a separate input, so transmit and receive can share one open-drain line. The bit period is `CLK_HZ/BAUD` clock cycles, and every character is 8N2: eleven bit periods long.

Top module: `swb_host`

## Requirements
- R1: While in reset and right after it, `busy`, `done`, `timeout_err` and `line_pull_low` are 0 and `rdata` is 0.
- R2: Each bus bit is one 8N2 character sent LSB first with a bit period of `CLK_HZ/BAUD` cycles. A bus 1 is sent as 0xFE, which pulls the line low for exactly 2 bit periods. A bus 0 is sent as 0xC0, which pulls it low for exactly 7 bit periods. Two characters never start less than 11 bit periods apart.
- R3: The command byte is `{rd_wr, addr[6:0]}`, with `rd_wr` in bit 7 and 1 meaning read. It goes out LSB first. A write (`rd_wr`=0) then sends `wdata` LSB first, for 16 characters in total.
- R4: In a read, the host sends only the 8 command characters and then receives 8 characters. The i-th received character gives bit i of `rdata`, which is updated when `done` pulses.
- R5: A received character whose value is above 0xF8 decodes to 1, and any other value decodes to 0. So 0xFE and 0xFC give 1, while 0xF8, 0xF0, 0xE0, 0xC0, 0x80 and 0x00 give 0.
- R6: The block's own transmitted characters, echoed on the shared wire, are never taken as read data. A write leaves `rdata` unchanged.
- R7: A `start` seen while idle latches `rd_wr`, `addr` and `wdata`, and `busy` is 1 from the next cycle. At the end, `done` is high for exactly one cycle, and `busy` falls in that same cycle.
- R8: A `start` pulse while `busy` is 1 has no effect on the transaction in progress and does not begin another.
- R9: If no start bit arrives within `TMO_FRAMES` character times during the read phase, the transaction ends with `done` and `timeout_err`=1, and `rdata` is unchanged. `timeout_err` holds until the next accepted `start` clears it.
- R10: A low pulse on `line_in` that is shorter than half a bit period is not taken as a character.
- R11: `line_pull_low` is 0 whenever the block is idle and throughout the receive phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 7 | Target register address |
| wdata | input | 8 | Data byte for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Byte assembled by the last successful read |
| timeout_err | output | 1 | Last read ended without an answer character |
| line_in | input | 1 | Sensed level of the shared wire |
| line_pull_low | output | 1 | 1 pulls the shared wire low, 0 releases it |

## Verification
`busy` is due one cycle after `start` is accepted. Each transmitted low pulse lasts exactly 2 or 7 bit periods, so the bench measures every pulse on the falling clock edge in whole cycles rather than at fixed offsets. A read's `done` arrives near the middle of the last answer character's first stop bit. For that reason the bench stops driving right after that character's low time and polls `done` from then on, so the one-cycle pulse cannot be missed. A timed-out read must finish between `TMO_FRAMES` character times plus the 4-bit-period tail of the last command character and the same plus its 9-bit-period tail, with a few cycles of synchronizer margin. The bench checks that window in cycles, counted from the end of the last command low pulse.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int FRAME_BITS = 11;

  localparam logic [7:0] CHAR_ONE  = 8'hFE;
  localparam logic [7:0] CHAR_ZERO = 8'hC0;
  localparam logic [7:0] RX_THRESH = 8'hF8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_READ
  } host_st_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_st_e;

  // Character that carries one bus bit.
  function automatic logic [7:0] bus_char(input logic b);
    return b ? CHAR_ONE : CHAR_ZERO;
  endfunction

  // Threshold decision on a received character.
  function automatic logic char_level(input logic [7:0] c);
    return c > RX_THRESH;
  endfunction

endpackage

// File: rtl/swb_rst_sync.sv
module swb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_out = s2_q;

endmodule

// File: rtl/swb_uart_tx.sv
module swb_uart_tx #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic bus_bit,
  output logic busy,
  output logic done,
  output logic pull_low
);
  import swb_pkg::*;

  localparam int CW = $clog2(DIV);
  localparam int BW = $clog2(FRAME_BITS + 1);

  logic                  act_q, act_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [BW-1:0]         nb_q, nb_d;
  logic                  done_q, done_d;

  always_comb begin
    act_d  = act_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    nb_d   = nb_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        sh_d  = {2'b11, bus_char(bus_bit), 1'b0};
        cnt_d = '0;
        nb_d  = '0;
      end
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
      if (nb_q == BW'(FRAME_BITS - 1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        nb_d = nb_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      nb_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      nb_q   <= nb_d;
      done_q <= done_d;
    end
  end

  assign busy     = act_q;
  assign done     = done_q;
  assign pull_low = act_q & ~sh_q[0];

endmodule

// File: rtl/swb_uart_rx.sv
module swb_uart_rx #(
  parameter int DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       line_in,
  output logic       busy,
  output logic       valid,
  output logic [7:0] data
);
  import swb_pkg::*;

  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic          s1_q, s2_q, s3_q;
  rx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    nb_q, nb_d;
  logic [7:0]    sh_q, sh_d;
  logic          valid_q, valid_d;
  logic          fall;

  assign fall = s3_q & ~s2_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    nb_d    = nb_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    if (!en) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (fall) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            nb_d  = '0;
            st_d  = s2_q ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CW'(DIV - 1)) begin
            cnt_d = '0;
            sh_d  = {s2_q, sh_q[7:1]};
            if (nb_q == 3'd7) st_d = RX_STOP;
            else              nb_d = nb_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CW'(DIV - 1)) begin
            st_d    = RX_IDLE;
            valid_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      s3_q    <= 1'b1;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      nb_q    <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      s1_q    <= line_in;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      nb_q    <= nb_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
    end
  end

  assign busy  = (st_q != RX_IDLE);
  assign valid = valid_q;
  assign data  = sh_q;

endmodule

// File: rtl/swb_host.sv
module swb_host #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int BAUD       = 57_600,
  parameter int TMO_FRAMES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_wr,
  input  logic [6:0] addr,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       timeout_err,
  input  logic       line_in,
  output logic       line_pull_low
);
  import swb_pkg::*;

  localparam int DIV       = CLK_HZ / BAUD;
  localparam int FRAME_CYC = DIV * FRAME_BITS;
  localparam int TMO_CYC   = TMO_FRAMES * FRAME_CYC;
  localparam int TW        = $clog2(TMO_CYC + 1);

  logic          rst_s;
  host_st_e      st_q, st_d;
  logic [7:0]    cmd_q, cmd_d;
  logic [7:0]    wd_q, wd_d;
  logic [3:0]    idx_q, idx_d;
  logic [7:0]    rsh_q, rsh_d;
  logic [2:0]    rcnt_q, rcnt_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic [7:0]    rdata_q, rdata_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  logic          tx_go, tx_busy, tx_done, tx_bit;
  logic          rx_busy, rx_valid, rx_lvl;
  logic [7:0]    rx_data;
  logic [15:0]   stream;
  logic          rd_phase;

  swb_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  assign stream   = {wd_q, cmd_q};
  assign tx_bit   = stream[idx_q];
  assign rd_phase = (st_q == ST_READ);
  assign rx_lvl   = char_level(rx_data);

  swb_uart_tx #(.DIV(DIV)) u_tx (
    .clk      (clk),
    .rst_n    (rst_s),
    .go       (tx_go),
    .bus_bit  (tx_bit),
    .busy     (tx_busy),
    .done     (tx_done),
    .pull_low (line_pull_low)
  );

  swb_uart_rx #(.DIV(DIV)) u_rx (
    .clk     (clk),
    .rst_n   (rst_s),
    .en      (rd_phase),
    .line_in (line_in),
    .busy    (rx_busy),
    .valid   (rx_valid),
    .data    (rx_data)
  );

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    wd_d    = wd_q;
    idx_d   = idx_q;
    rsh_d   = rsh_q;
    rcnt_d  = rcnt_q;
    tmo_d   = tmo_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    done_d  = 1'b0;
    tx_go   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_SEND;
          cmd_d = {rd_wr, addr};
          wd_d  = wdata;
          idx_d = '0;
          err_d = 1'b0;
        end
      end
      ST_SEND: begin
        tx_go = !tx_busy && !tx_done;
        if (tx_done) begin
          if (idx_q == 4'd7 && cmd_q[7]) begin
            st_d   = ST_READ;
            rcnt_d = '0;
            tmo_d  = '0;
          end else if (idx_q == 4'd15) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_READ: begin
        if (rx_valid) begin
          rsh_d = {rx_lvl, rsh_q[7:1]};
          tmo_d = '0;
          if (rcnt_q == 3'd7) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            rdata_d = {rx_lvl, rsh_q[7:1]};
          end else begin
            rcnt_d = rcnt_q + 1'b1;
          end
        end else if (rx_busy) begin
          tmo_d = '0;
        end else if (tmo_q == TW'(TMO_CYC - 1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          err_d  = 1'b1;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      cmd_q   <= '0;
      wd_q    <= '0;
      idx_q   <= '0;
      rsh_q   <= '0;
      rcnt_q  <= '0;
      tmo_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      wd_q    <= wd_d;
      idx_q   <= idx_d;
      rsh_q   <= rsh_d;
      rcnt_q  <= rcnt_d;
      tmo_q   <= tmo_d;
      rdata_q <= rdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign rdata       = rdata_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/swb_host_chk.sv
module swb_host_chk #(
  parameter int DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic pull_low,
  input logic rd_phase
);

  localparam int RW = $clog2(8 * DIV + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (pull_low) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R2: every low pulse is exactly 2 or 7 bit periods
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_low) |-> (run_q == RW'(2 * DIV) || run_q == RW'(7 * DIV)));

  // R11: line released while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pull_low);

  // R11: line released in the receive phase
  a_r11_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !pull_low);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: busy falls together with done
  a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: error only raised at the end of a transaction
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);

endmodule

bind swb_host swb_host_chk #(.DIV(CLK_HZ / BAUD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .pull_low    (line_pull_low),
  .rd_phase    (rd_phase)
);

// File: tb/tb_swb_host.sv
module tb_swb_host;

  localparam int CLK_HZ = 576_000;
  localparam int BAUD   = 57_600;
  localparam int TMO    = 3;
  localparam int DIV    = CLK_HZ / BAUD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       rd_wr = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       tgt_low = 1'b0;
  logic       busy, done, timeout_err, pull_low;
  logic [7:0] rdata;
  logic       line;

  assign line = ~(pull_low | tgt_low);

  always #5 clk = ~clk;

  swb_host #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .TMO_FRAMES(TMO)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .rd_wr         (rd_wr),
    .addr          (addr),
    .wdata         (wdata),
    .busy          (busy),
    .done          (done),
    .rdata         (rdata),
    .timeout_err   (timeout_err),
    .line_in       (line),
    .line_pull_low (pull_low)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Monitor of host characters: measures each low pulse in cycles.
  logic        pl_prev = 1'b0;
  int          len = 0;
  int          tot = 0;
  logic [15:0] cap = '0;
  int          last_fall = 0;
  time         t_end = 0;

  always @(negedge clk) begin
    cyc++;
    if (pull_low) begin
      if (!pl_prev) begin
        if (tot > 0) begin
          checks++;
          if (cyc - last_fall < 11 * DIV) begin
            errors++;
            $display("FAIL R2 char spacing: actual %0d expected >= %0d", cyc - last_fall, 11 * DIV);
          end
        end
        last_fall = cyc;
      end
      len++;
    end else if (pl_prev) begin
      checks++;
      if (len == 2 * DIV)      cap = {1'b1, cap[15:1]};
      else if (len == 7 * DIV) cap = {1'b0, cap[15:1]};
      else begin
        errors++;
        $display("FAIL R2 low width: actual %0d expected %0d or %0d", len, 2 * DIV, 7 * DIV);
      end
      tot++;
      len = 0;
      t_end = $time;
    end
    pl_prev = pull_low;
    if (cyc == 150_000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  int  base;
  time t_done;

  task automatic kick(input logic rw, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    base  = tot;
    start = 1'b1;
    rd_wr = rw;
    addr  = a;
    wdata = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    chk(timeout_err == 1'b0, "R9 error cleared by start", timeout_err, 0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20_000) begin
      @(negedge clk);
      n++;
    end
    t_done = $time;
    chk(done == 1'b1, "R7 done seen", done, 1);
    chk(busy == 1'b0, "R7 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] prev = rdata;
    kick(1'b0, a, d);
    wait_done();
    chk(tot - base == 16, "R3 write char count", tot - base, 16);
    chk(cap[7:0] == {1'b0, a}, "R3 write command bits", cap[7:0], {1'b0, a});
    chk(cap[15:8] == d, "R3 write data bits", cap[15:8], d);
    chk(rdata == prev, "R6 echo not read back", rdata, prev);
  endtask

  // mode: 0 normal, 1 with a short glitch first, 2 silent target, 3 threshold edges
  task automatic do_read(input logic [6:0] a, input logic [7:0] v, input int mode);
    logic [7:0] prev = rdata;
    int n = 0;
    kick(1'b1, a, 8'h00);
    while (tot - base < 8 && n < 20_000) begin
      @(negedge clk);
      n++;
    end
    repeat (12 * DIV) @(negedge clk);
    if (mode == 1) begin
      tgt_low = 1'b1;
      repeat (2) @(negedge clk);
      tgt_low = 1'b0;
      repeat (8) @(negedge clk);
    end
    if (mode != 2) begin
      for (int i = 0; i < 8; i++) begin
        int lo;
        if (mode == 3) lo = v[i] ? 3 : 4;
        else           lo = v[i] ? 2 + ((i + int'(v)) % 2) : 4 + ((i + int'(v)) % 6);
        tgt_low = 1'b1;
        repeat (lo * DIV) @(negedge clk);
        tgt_low = 1'b0;
        if (i < 7) repeat ((12 - lo) * DIV) @(negedge clk);
      end
    end
    wait_done();
    chk(cap[15:8] == {1'b1, a}, "R3 read command bits", cap[15:8], {1'b1, a});
    chk(tot - base == 8, "R11 host silent in read phase", tot - base, 8);
    if (mode == 2) begin
      int dl = int'((t_done - t_end) / 10);
      chk(timeout_err == 1'b1, "R9 timeout flag", timeout_err, 1);
      chk(rdata == prev, "R9 rdata kept on timeout", rdata, prev);
      chk(dl >= TMO * 11 * DIV + 4 * DIV && dl <= TMO * 11 * DIV + 9 * DIV + 8,
          "R9 timeout delay", dl, TMO * 11 * DIV + 9 * DIV);
    end else begin
      chk(timeout_err == 1'b0, "R4 no error on answered read", timeout_err, 0);
      if (mode == 1)      chk(rdata == v, "R10 glitch ignored", rdata, v);
      else if (mode == 3) chk(rdata == v, "R5 threshold 0xFC/0xF8", rdata, v);
      else                chk(rdata == v, "R4 read data assembled", rdata, v);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(pull_low == 1'b0, "R1 line released in reset", pull_low, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 0);
    chk(timeout_err == 1'b0, "R1 error clear", timeout_err, 0);
    chk(rdata == 8'h00, "R1 rdata zero", rdata, 0);
    chk(pull_low == 1'b0, "R11 idle line", pull_low, 0);

    for (int k = 0; k < 20; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      a = (k == 0) ? 7'h00 : (k == 1) ? 7'h7F : 7'((k * 37 + 5) & 127);
      d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 73 + 11) & 255);
      do_write(a, d);
    end

    for (int k = 0; k < 12; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 29 + 3) & 255);
      do_read(7'((k * 11 + 2) & 127), v, k % 2);
    end
    do_read(7'h15, 8'hA5, 3);
    do_read(7'h6A, 8'h3C, 3);

    // R6: rdata holds across a write after a read
    do_write(7'h33, 8'h5A);

    // R8: start while busy
    kick(1'b0, 7'h21, 8'h96);
    while (tot - base < 3) @(negedge clk);
    start = 1'b1;
    rd_wr = 1'b1;
    addr  = 7'h4C;
    wdata = 8'h01;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(tot - base == 16, "R8 char count unchanged", tot - base, 16);
    chk(cap == {8'h96, 1'b0, 7'h21}, "R8 frame unchanged", cap, {8'h96, 1'b0, 7'h21});
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && tot - base == 16, "R8 no second transaction", tot - base, 16);

    // R9: silent target, then the next start clears the flag
    do_read(7'h2B, 8'h00, 2);
    chk(timeout_err == 1'b1, "R9 flag held while idle", timeout_err, 1);
    do_write(7'h01, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule